// File: doc/BRIEF.md
# Pipelined Byte-Lane Synchronous SRAM

This block is a single-clock synchronous static RAM. Each word is 36 bits, split into four 9-bit byte lanes. The rising clock edge captures every input: address, write data, the three chip enables, the global write strobe, the byte-write strobe and one select per lane. A write can change any subset of the lanes. A read returns the whole word through one output register. The shared data bus is modelled as a data input, a data output and an output enable.

Three chip enables qualify each cycle, so several instances can be stacked in depth by decoding upper address bits onto the enables. When a cycle is deselected, or when it is a write, the bus is released after a single pipeline stage. Any burst address generation sits outside this block and feeds the address input.

Top module: `sram_pipe_top`

## Requirements
- R1: While reset is held low at a clock edge, `dq_oe` is low after that edge, and it stays low until a selected read has been registered.
- R2: A read registered at clock edge k puts the stored word on `dq_o` with `dq_oe` high after edge k+1. A read is a selected cycle with `gw_n` high and `bwe_n` high.
- R3: A selected cycle with `gw_n` high and `bwe_n` low writes every lane k whose `bsel_n[k]` is low. Lane k is bits 9k+8 down to 9k of `dq_i`. The other lanes keep their contents.
- R4: A selected cycle with `gw_n` low writes all four lanes, whatever the values of `bwe_n` and `bsel_n`.
- R5: A selected cycle with `gw_n` high and `bwe_n` high changes no stored data, whatever the value of `bsel_n`.
- R6: A cycle is selected only when `ce_a_n` is low, `ce_b` is high and `ce_c_n` is low. A deselected cycle changes no stored data and does not drive the bus.
- R7: After a deselected cycle or a write cycle is registered at edge k, `dq_oe` is low after edge k+1.
- R8: A read registered at the edge right after a write to the same address returns the newly written lanes.
- R9: A selected cycle with `gw_n` high, `bwe_n` low and all `bsel_n` bits high changes no stored data and does not drive the bus.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all inputs are sampled on its rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| addr_i | input | ADDR_W | Word address |
| dq_i | input | 36 | Write data, incoming half of the shared bus |
| ce_a_n | input | 1 | Chip enable, active low |
| ce_b | input | 1 | Chip enable, active high |
| ce_c_n | input | 1 | Chip enable, active low |
| gw_n | input | 1 | Global write of all lanes, active low |
| bwe_n | input | 1 | Byte-write enable, active low |
| bsel_n | input | 4 | Per-lane write select, active low; bit k selects lane k |
| dq_o | output | 36 | Read data, outgoing half of the shared bus |
| dq_oe | output | 1 | High while the block drives the bus |

## Verification
Every result of this block arrives on the second rising edge after its inputs are applied. The first edge registers the command. The second edge performs the write, or loads the output register and the output enable. Each command the bench drives therefore carries a due cycle two edges after the edge count at drive time. The monitor compares an item only once that many edges have passed, and it samples one nanosecond after the edge. Stored contents are checked only through later reads, which are due on the same two-edge schedule. A read issued directly behind a write is due one edge after the write lands in the array.

// File: rtl/sram_pipe_pkg.sv
// Package: shared types for the pipelined byte-lane SRAM.
// Assumes: one command per clock; a command is idle, a read or a write.
package sram_pipe_pkg;

    // Kind of command captured in the input register.
    typedef enum logic [1:0] {
        OP_NONE  = 2'd0,
        OP_READ  = 2'd1,
        OP_WRITE = 2'd2
    } sram_op_e;

endpackage

// File: rtl/sram_ctl_decode.sv
// Module: sram_ctl_decode
// Turns the raw strobes of one cycle into a command kind and a per-lane
// write mask. Global write wins over byte writes. Byte writes use the
// active-low lane selects. A deselected cycle yields no command.
// Assumes: all strobes are active low except ce_b.
module sram_ctl_decode
    import sram_pipe_pkg::*;
#(
    parameter int LANES = 4
) (
    input  logic             ce_a_n,
    input  logic             ce_b,
    input  logic             ce_c_n,
    input  logic             gw_n,
    input  logic             bwe_n,
    input  logic [LANES-1:0] bsel_n,
    output sram_op_e         op,
    output logic [LANES-1:0] lane_we
);

    logic selected;

    // Chip selection: all three enables at their active level.
    always_comb begin
        selected = !ce_a_n && ce_b && !ce_c_n;
    end

    // Command and lane mask, global write first.
    always_comb begin
        op      = OP_NONE;
        lane_we = '0;
        if (selected) begin
            if (!gw_n) begin
                op      = OP_WRITE;
                lane_we = '1;
            end else if (!bwe_n) begin
                op      = OP_WRITE;
                lane_we = ~bsel_n;
            end else begin
                op      = OP_READ;
            end
        end
    end

endmodule

// File: rtl/sram_in_stage.sv
// Module: sram_in_stage
// The input register stage. It holds the decoded command, the lane mask,
// the address and the write data for one cycle.
// Assumes: synchronous active-low reset clears only the command and mask.
module sram_in_stage
    import sram_pipe_pkg::*;
#(
    parameter int ADDR_W = 6,
    parameter int LANES  = 4,
    parameter int LANE_W = 9,
    localparam int DATA_W = LANES * LANE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  sram_op_e          op_d,
    input  logic [LANES-1:0]  we_d,
    input  logic [ADDR_W-1:0] addr_d,
    input  logic [DATA_W-1:0] data_d,
    output sram_op_e          op_q,
    output logic [LANES-1:0]  we_q,
    output logic [ADDR_W-1:0] addr_q,
    output logic [DATA_W-1:0] data_q
);

    // Capture the command and its control; reset leaves an idle command.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            op_q <= OP_NONE;
            we_q <= '0;
        end else begin
            op_q <= op_d;
            we_q <= we_d;
        end
    end

    // Capture address and data; they have no meaning without a command.
    always_ff @(posedge clk) begin
        addr_q <= addr_d;
        data_q <= data_d;
    end

endmodule

// File: rtl/sram_array.sv
// Module: sram_array
// Storage split into one narrow memory per byte lane. Each lane is written
// on its own enable. The read port is combinational and returns the
// contents as of the last edge.
// Assumes: contents are not reset; a single address serves both ports.
module sram_array #(
    parameter int ADDR_W = 6,
    parameter int LANES  = 4,
    parameter int LANE_W = 9,
    localparam int DEPTH  = 1 << ADDR_W,
    localparam int DATA_W = LANES * LANE_W
) (
    input  logic              clk,
    input  logic [LANES-1:0]  lane_we,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata
);

    for (genvar k = 0; k < LANES; k++) begin : g_lane
        logic [LANE_W-1:0] cells [DEPTH];

        // Lane write: update this lane only when its enable is set.
        always_ff @(posedge clk) begin
            if (lane_we[k]) begin
                cells[addr] <= wdata[k*LANE_W +: LANE_W];
            end
        end

        // Lane read: present the addressed cell of this lane.
        always_comb begin
            rdata[k*LANE_W +: LANE_W] = cells[addr];
        end
    end

endmodule

// File: rtl/sram_out_stage.sv
// Module: sram_out_stage
// The output register and the output-enable register. A registered read
// loads the word and raises the enable. Any other command drops the
// enable at the next edge.
// Assumes: synchronous active-low reset releases the bus.
module sram_out_stage
    import sram_pipe_pkg::*;
#(
    parameter int DATA_W = 36
) (
    input  logic              clk,
    input  logic              rst_n,
    input  sram_op_e          op_q,
    input  logic [DATA_W-1:0] rdata,
    output logic [DATA_W-1:0] dq_o,
    output logic              dq_oe
);

    // Output enable follows the command one stage later.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dq_oe <= 1'b0;
        end else begin
            dq_oe <= (op_q == OP_READ);
        end
    end

    // Output data loads only on a read and holds otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dq_o <= '0;
        end else if (op_q == OP_READ) begin
            dq_o <= rdata;
        end
    end

endmodule

// File: rtl/sram_pipe_top.sv
// Module: sram_pipe_top
// A pipelined synchronous SRAM with byte-lane writes. The chain is:
// decode, input register, lane array, output register. Results appear
// two edges after the inputs, and the bus is released after one stage.
// Assumes: a single clock; burst addresses come from outside.
module sram_pipe_top
    import sram_pipe_pkg::*;
#(
    parameter int ADDR_W = 6,
    parameter int LANES  = 4,
    parameter int LANE_W = 9,
    localparam int DATA_W = LANES * LANE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [DATA_W-1:0] dq_i,
    input  logic              ce_a_n,
    input  logic              ce_b,
    input  logic              ce_c_n,
    input  logic              gw_n,
    input  logic              bwe_n,
    input  logic [LANES-1:0]  bsel_n,
    output logic [DATA_W-1:0] dq_o,
    output logic              dq_oe
);

    sram_op_e          op_d;
    sram_op_e          op_q;
    logic [LANES-1:0]  we_d;
    logic [LANES-1:0]  we_q;
    logic [ADDR_W-1:0] addr_q;
    logic [DATA_W-1:0] data_q;
    logic [DATA_W-1:0] rdata;

    sram_ctl_decode #(.LANES(LANES)) u_decode (
        .ce_a_n  (ce_a_n),
        .ce_b    (ce_b),
        .ce_c_n  (ce_c_n),
        .gw_n    (gw_n),
        .bwe_n   (bwe_n),
        .bsel_n  (bsel_n),
        .op      (op_d),
        .lane_we (we_d)
    );

    sram_in_stage #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) u_in (
        .clk    (clk),
        .rst_n  (rst_n),
        .op_d   (op_d),
        .we_d   (we_d),
        .addr_d (addr_i),
        .data_d (dq_i),
        .op_q   (op_q),
        .we_q   (we_q),
        .addr_q (addr_q),
        .data_q (data_q)
    );

    sram_array #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) u_array (
        .clk     (clk),
        .lane_we (we_q),
        .addr    (addr_q),
        .wdata   (data_q),
        .rdata   (rdata)
    );

    sram_out_stage #(.DATA_W(DATA_W)) u_out (
        .clk   (clk),
        .rst_n (rst_n),
        .op_q  (op_q),
        .rdata (rdata),
        .dq_o  (dq_o),
        .dq_oe (dq_oe)
    );

    logic port_sel;
    logic port_rd;

    // Port-level view of selection and read, used only by the properties.
    always_comb begin
        port_sel = !ce_a_n && ce_b && !ce_c_n;
        port_rd  = port_sel && gw_n && bwe_n;
    end

    // R2: a selected read at the ports drives the bus two edges later.
    p_read_drives_r2: assert property (@(posedge clk) disable iff (!rst_n)
        port_rd |=> ##1 dq_oe);

    // R7: a deselected or write cycle releases the bus two edges later.
    p_release_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !port_rd |=> ##1 !dq_oe);

    // R4: global write on a selected cycle enables every lane in the array.
    p_global_all_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (port_sel && !gw_n) |=> (we_q == {LANES{1'b1}}));

    // R3: a byte write enables exactly the lanes whose selects were low.
    p_byte_lanes_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (port_sel && gw_n && !bwe_n) |=> (we_q == ~$past(bsel_n)));

    // R6: a deselected cycle enables no lane.
    p_desel_no_write_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !port_sel |=> (we_q == '0));

endmodule

// File: tb/sram_pipe_top_tb_top.sv
// Scoreboard bench: the driver pushes expected results, and the monitor
// compares them once their due edge has passed.
module sram_pipe_top_tb_top;

    localparam int AW = 6;
    localparam int DW = 36;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [AW-1:0] addr_i = '0;
    logic [DW-1:0] dq_i = '0;
    logic          ce_a_n = 1'b1;
    logic          ce_b = 1'b0;
    logic          ce_c_n = 1'b1;
    logic          gw_n = 1'b1;
    logic          bwe_n = 1'b1;
    logic [3:0]    bsel_n = 4'hF;
    logic [DW-1:0] dq_o;
    logic          dq_oe;

    int checks = 0;
    int errors = 0;
    longint cyc = 0;
    bit done = 1'b0;

    typedef struct {
        longint        due;
        bit            exp_oe;
        logic [DW-1:0] exp_d;
        string         tag;
    } item_t;

    item_t sb[$];
    logic [DW-1:0] model [1<<AW];

    sram_pipe_top dut_i (
        .clk(clk), .rst_n(rst_n), .addr_i(addr_i), .dq_i(dq_i),
        .ce_a_n(ce_a_n), .ce_b(ce_b), .ce_c_n(ce_c_n), .gw_n(gw_n),
        .bwe_n(bwe_n), .bsel_n(bsel_n), .dq_o(dq_o), .dq_oe(dq_oe)
    );

    always #2 clk = ~clk;

    always @(posedge clk) cyc = cyc + 1;

    task automatic chk(bit ok, string tag, logic [DW-1:0] act, logic [DW-1:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Drive one command and push its expected bus result.
    task automatic drive(bit a_n, bit b, bit c_n, bit g_n, bit bw_n, logic [3:0] bs_n,
                         logic [AW-1:0] a, logic [DW-1:0] d, string tag);
        item_t it;
        bit sel;
        @(negedge clk);
        ce_a_n = a_n; ce_b = b; ce_c_n = c_n; gw_n = g_n; bwe_n = bw_n;
        bsel_n = bs_n; addr_i = a; dq_i = d;
        sel = !a_n && b && !c_n;
        it.due = cyc + 2;
        it.tag = tag;
        it.exp_oe = sel && g_n && bw_n;
        it.exp_d = it.exp_oe ? model[a] : '0;
        if (sel && !g_n) begin
            model[a] = d;
        end else if (sel && !bw_n) begin
            for (int k = 0; k < 4; k++)
                if (!bs_n[k]) model[a][9*k +: 9] = d[9*k +: 9];
        end
        sb.push_back(it);
    endtask

    task automatic wr_all(logic [AW-1:0] a, logic [DW-1:0] d, string tag);
        drive(0, 1, 0, 0, 1, 4'hF, a, d, tag);
    endtask

    task automatic rd(logic [AW-1:0] a, string tag);
        drive(0, 1, 0, 1, 1, 4'hF, a, 36'h0, tag);
    endtask

    task automatic idle();
        drive(1, 0, 1, 1, 1, 4'hF, '0, '0, "R7 idle");
    endtask

    // Monitor: compare every item once its due edge has passed.
    initial begin
        forever begin
            @(posedge clk);
            #1;
            while (sb.size() > 0 && sb[0].due <= cyc) begin
                item_t it;
                it = sb.pop_front();
                chk(dq_oe === it.exp_oe, {it.tag, " oe"}, {35'h0, dq_oe}, {35'h0, it.exp_oe});
                if (it.exp_oe)
                    chk(dq_o === it.exp_d, {it.tag, " data"}, dq_o, it.exp_d);
            end
        end
    end

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        #40000;
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        #1;
        chk(dq_oe === 1'b0, "R1 reset oe", {35'h0, dq_oe}, 36'h0);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        chk(dq_oe === 1'b0, "R1 after reset oe", {35'h0, dq_oe}, 36'h0);

        // Fill a few words with global writes (R4), then read them (R2).
        for (int i = 0; i < 8; i++)
            wr_all(AW'(i), {4{9'(i * 37 + 5)}}, "R4 fill");
        for (int i = 0; i < 8; i++)
            rd(AW'(i), "R2 read fill");

        // Global write ignores bwe_n and bsel_n (R4).
        drive(0, 1, 0, 0, 0, 4'b1010, 6'd1, 36'h123456789, "R4 gw over bsel");
        rd(6'd1, "R4 read gw");

        // Byte write of lanes 0 and 2 (R3).
        drive(0, 1, 0, 1, 0, 4'b1010, 6'd0, 36'hABCDEF012, "R3 bytes 0,2");
        idle();
        rd(6'd0, "R3 read bytes");
        drive(0, 1, 0, 1, 0, 4'b0111, 6'd2, 36'hFFFFFFFFF, "R3 byte 3");
        idle();
        rd(6'd2, "R3 read byte 3");

        // Byte-write enable with no lane selected (R9).
        drive(0, 1, 0, 1, 0, 4'hF, 6'd3, 36'h0, "R9 empty write");
        idle();
        rd(6'd3, "R9 read back");

        // Read with lane selects low changes nothing (R5).
        drive(0, 1, 0, 1, 1, 4'h0, 6'd4, 36'h0FFFF0000, "R5 read bsel low");
        idle();
        rd(6'd4, "R5 read back");

        // Each enable alone deselects: no write, no drive (R6).
        drive(1, 1, 0, 0, 1, 4'hF, 6'd5, 36'h111111111, "R6 ce_a high");
        drive(0, 0, 0, 0, 1, 4'hF, 6'd5, 36'h222222222, "R6 ce_b low");
        drive(0, 1, 1, 0, 1, 4'hF, 6'd5, 36'h333333333, "R6 ce_c high");
        drive(1, 1, 0, 1, 1, 4'hF, 6'd5, 36'h0, "R6 desel read");
        rd(6'd5, "R6 read back");

        // Read, then deselect, then write: the bus drops each time (R7).
        rd(6'd6, "R7 read before");
        idle();
        rd(6'd7, "R7 read before write");
        wr_all(6'd9, 36'h5A5A5A5A5, "R7 write drops oe");

        // Back-to-back write and read of the same address (R8).
        wr_all(6'd10, 36'hC3C3C3C3C, "R8 write");
        rd(6'd10, "R8 raw read");
        drive(0, 1, 0, 1, 0, 4'b1110, 6'd10, 36'h000000155, "R8 byte write");
        rd(6'd10, "R8 raw byte read");

        // A burst of reads back to back (R2).
        for (int i = 7; i >= 0; i--)
            rd(AW'(i), "R2 burst read");

        repeat (4) idle();
        repeat (4) @(negedge clk);
        done = 1'b1;
        if (sb.size() != 0) begin
            checks++;
            errors++;
            $display("FAIL R2 pending actual=%0d expected=%0d", sb.size(), 0);
        end
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule